// File: doc/BRIEF.md
# Excluding Random Memory Tag Generator

This block puts a pseudo-random 4-bit allocation tag into the tag field of a 64-bit pointer. It keeps a state register that holds a 16-bit linear feedback shift register seed and a 4-bit start tag. When a request is accepted, the seed is advanced four steps. The feedback bits from those steps form an offset. Starting from the stored start tag, the block then walks forward, modulo 16, to the offset-th tag that the exclusion mask allows. The exclusion mask is the OR of a per-request mask and a configuration mask. The chosen tag is reduced by pointer bit 55, modulo 16, and written into pointer bits 59:56. The state register is reloaded with the chosen tag and the advanced seed.

The control is a state machine with four states. In `S_IDLE` the block waits for a request. In `S_SETTLE` it handles offset zero: it steps forward while the current tag is excluded. In `S_STEP` it handles a nonzero offset: it visits one tag per clock and counts down on each allowed tag. In `S_DONE` it presents the result for one cycle.

The transitions are:
- An accepted request goes from `S_IDLE` to `S_DONE` when tagging is disabled or when every tag is excluded.
- Otherwise it goes to `S_SETTLE` for offset zero, or to `S_STEP` for any other offset.
- `S_SETTLE` goes to `S_DONE` on the first allowed tag.
- `S_STEP` goes to `S_DONE` when the last allowed tag of the count is reached.
- `S_DONE` always returns to `S_IDLE`.

Software loads the seed and the start tag through a direct write port.

Top module: `tagrand_top`

## Requirements
- R1: After reset, `st_q` is 0, and `busy` and `done` are low.
- R2: The exclusion mask is `req_mask | cfg_mask`. Mask bit n set means tag n cannot be chosen.
- R3: Each request advances the seed (`st_q[23:8]`) four times. In each step, a new bit is formed as the XOR of seed bits 5, 3, 2 and 0. The seed then shifts right by one and the new bit enters bit 15. The new bit from step i is bit i of the offset.
- R4: With offset 0, the tag starts at the start tag (`st_q[3:0]`) and increments modulo 16 while the current tag is excluded.
- R5: With a nonzero offset, the tag moves, once per unit of offset, to the next allowed tag. Each move is at least one increment, modulo 16.
- R6: If all 16 exclusion bits are set, the chosen tag is 0. The seed still advances.
- R7: When tagging is enabled, `st_q` after the request holds the chosen tag in bits 3:0, zero in bits 7:4 and the advanced seed in bits 23:8. While the block is busy and `done` is low, `st_q` does not change.
- R8: With `tag_en` low at acceptance, the chosen tag is 0 and `st_q` is left unchanged.
- R9: `res_ptr` equals the request pointer with bits 59:56 replaced by (chosen tag − pointer bit 55) mod 16.
- R10: `done` pulses for exactly one cycle per accepted request, with `res_ptr` and `st_q` valid. `busy` is high from acceptance through the `done` cycle. Requests that arrive while busy are ignored.
- R11: In idle, `st_wr_en` loads `st_wr_data[3:0]` as the start tag and `st_wr_data[23:8]` as the seed, and bits 7:4 read back as 0. A write takes priority over a request in the same cycle, and that request is dropped. Writes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted in idle |
| req_ptr | input | 64 | Pointer to be tagged |
| req_mask | input | 16 | Per-request exclusion mask |
| cfg_mask | input | 16 | Configuration exclusion mask |
| tag_en | input | 1 | Tag generation enabled |
| st_wr_en | input | 1 | State register write strobe |
| st_wr_data | input | 24 | State write data: seed in 23:8, start tag in 3:0 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result valid pulse |
| res_ptr | output | 64 | Tagged pointer |
| st_q | output | 24 | Current state register |

## Verification
The bench builds the block with its default parameters: a 64-bit pointer, a 4-bit tag, a 16-bit seed and four LFSR steps per request. With these values the full 16-entry exclusion mask is in play. That makes the all-excluded case and single-allowed-tag masks reachable, as well as offsets up to 15 whose walk wraps past tag 15 several times. Pointers with bit 55 set exercise the wrap of the biased tag below zero. The bench also covers disabled tagging, stray requests and writes during a walk, and a write that collides with a request.

// File: rtl/tagrand_pkg.sv
package tagrand_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETTLE = 2'd1,
        S_STEP   = 2'd2,
        S_DONE   = 2'd3
    } fsm_t;
endpackage

// File: rtl/tagrand_lfsr.sv
// Advances the seed STEPS times in one cycle and collects the feedback bits.
module tagrand_lfsr #(
    parameter int SEED_W = 16,
    parameter int STEPS  = 4,
    parameter int TAP_A  = 5,
    parameter int TAP_B  = 3,
    parameter int TAP_C  = 2,
    parameter int TAP_D  = 0
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o,
    output logic [STEPS-1:0]  offset_o
);
    logic [SEED_W-1:0] chain [0:STEPS];

    assign chain[0] = seed_i;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign offset_o[g] = chain[g][TAP_A] ^ chain[g][TAP_B]
                           ^ chain[g][TAP_C] ^ chain[g][TAP_D];
        assign chain[g+1]  = {offset_o[g], chain[g][SEED_W-1:1]};
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/tagrand_state.sv
// Holds the start tag and the seed.
module tagrand_state #(
    parameter int TAG_W  = 4,
    parameter int SEED_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SEED_W-1:0] wr_seed,
    output logic [TAG_W-1:0]  tag_q,
    output logic [SEED_W-1:0] seed_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            seed_q <= '0;
        end else if (wr_en) begin
            tag_q  <= wr_tag;
            seed_q <= wr_seed;
        end
    end
endmodule

// File: rtl/tagrand_insert.sv
// Deposits the biased tag into the pointer's tag field.
module tagrand_insert #(
    parameter int PTR_W    = 64,
    parameter int TAG_W    = 4,
    parameter int TAG_LSB  = 56,
    parameter int BIAS_BIT = 55
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [PTR_W-1:0] ptr_o
);
    always_comb begin
        ptr_o = ptr_i;
        ptr_o[TAG_LSB +: TAG_W] = tag_i - TAG_W'(ptr_i[BIAS_BIT]);
    end
endmodule

// File: rtl/tagrand_top.sv
module tagrand_top
    import tagrand_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int TAG_W    = 4,
    parameter int SEED_W   = 16,
    parameter int SEED_LSB = 8,
    parameter int TAG_LSB  = 56,
    parameter int BIAS_BIT = 55,
    parameter int STEPS    = 4,
    localparam int NTAGS   = 1 << TAG_W,
    localparam int ST_W    = SEED_LSB + SEED_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PTR_W-1:0] req_ptr,
    input  logic [NTAGS-1:0] req_mask,
    input  logic [NTAGS-1:0] cfg_mask,
    input  logic             tag_en,
    input  logic             st_wr_en,
    input  logic [ST_W-1:0]  st_wr_data,
    output logic             busy,
    output logic             done,
    output logic [PTR_W-1:0] res_ptr,
    output logic [ST_W-1:0]  st_q
);
    localparam int GAP_W = SEED_LSB - TAG_W;

    fsm_t              cs, ns;
    logic [PTR_W-1:0]  ptr_q;
    logic [NTAGS-1:0]  excl_q;
    logic              en_q;
    logic [TAG_W-1:0]  cur_q;
    logic [TAG_W-1:0]  cur_inc;
    logic [STEPS-1:0]  cnt_q;
    logic [SEED_W-1:0] seed_nx_q;
    logic [TAG_W-1:0]  res_tag_q;

    logic [NTAGS-1:0]  excl_in;
    logic              accept;
    logic              commit;
    logic [TAG_W-1:0]  fin_tag;
    logic [SEED_W-1:0] commit_seed;

    logic [TAG_W-1:0]  start_tag;
    logic [SEED_W-1:0] seed_cur;
    logic [SEED_W-1:0] seed_adv;
    logic [STEPS-1:0]  offset;

    logic              sw_wr;
    logic              st_we;
    logic [TAG_W-1:0]  st_wtag;
    logic [SEED_W-1:0] st_wseed;

    tagrand_lfsr #(.SEED_W(SEED_W), .STEPS(STEPS)) u_lfsr (
        .seed_i   (seed_cur),
        .seed_o   (seed_adv),
        .offset_o (offset)
    );

    tagrand_state #(.TAG_W(TAG_W), .SEED_W(SEED_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_we),
        .wr_tag  (st_wtag),
        .wr_seed (st_wseed),
        .tag_q   (start_tag),
        .seed_q  (seed_cur)
    );

    tagrand_insert #(
        .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB), .BIAS_BIT(BIAS_BIT)
    ) u_insert (
        .ptr_i (ptr_q),
        .tag_i (res_tag_q),
        .ptr_o (res_ptr)
    );

    assign excl_in = req_mask | cfg_mask;
    assign cur_inc = cur_q + TAG_W'(1);
    assign sw_wr   = (cs == S_IDLE) && st_wr_en;
    assign accept  = (cs == S_IDLE) && req_valid && !st_wr_en;

    // Next state and commit decision
    always_comb begin
        ns      = cs;
        commit  = 1'b0;
        fin_tag = cur_q;
        unique case (cs)
            S_IDLE: begin
                if (accept) begin
                    if (!tag_en) begin
                        ns = S_DONE;
                    end else if (&excl_in) begin
                        ns      = S_DONE;
                        commit  = 1'b1;
                        fin_tag = '0;
                    end else if (offset == '0) begin
                        ns = S_SETTLE;
                    end else begin
                        ns = S_STEP;
                    end
                end
            end
            S_SETTLE: begin
                if (!excl_q[cur_q]) begin
                    ns      = S_DONE;
                    commit  = 1'b1;
                    fin_tag = cur_q;
                end
            end
            S_STEP: begin
                if (!excl_q[cur_inc] && cnt_q == STEPS'(1)) begin
                    ns      = S_DONE;
                    commit  = 1'b1;
                    fin_tag = cur_inc;
                end
            end
            S_DONE: ns = S_IDLE;
            default: ns = S_IDLE;
        endcase
    end

    assign commit_seed = (cs == S_IDLE) ? seed_adv : seed_nx_q;
    assign st_we       = commit | sw_wr;
    assign st_wtag     = commit ? fin_tag : st_wr_data[TAG_W-1:0];
    assign st_wseed    = commit ? commit_seed : st_wr_data[SEED_LSB +: SEED_W];

    // State register and walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs        <= S_IDLE;
            ptr_q     <= '0;
            excl_q    <= '0;
            en_q      <= 1'b0;
            cur_q     <= '0;
            cnt_q     <= '0;
            seed_nx_q <= '0;
            res_tag_q <= '0;
        end else begin
            cs <= ns;
            if (accept) begin
                ptr_q     <= req_ptr;
                excl_q    <= excl_in;
                en_q      <= tag_en;
                cur_q     <= start_tag;
                cnt_q     <= offset;
                seed_nx_q <= seed_adv;
            end
            if (cs == S_SETTLE && excl_q[cur_q]) begin
                cur_q <= cur_inc;
            end
            if (cs == S_STEP) begin
                cur_q <= cur_inc;
                if (!excl_q[cur_inc]) begin
                    cnt_q <= cnt_q - STEPS'(1);
                end
            end
            if (ns == S_DONE && cs != S_DONE) begin
                res_tag_q <= commit ? fin_tag : '0;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (cs != S_IDLE);
        done = (cs == S_DONE);
        st_q = {seed_cur, GAP_W'(0), start_tag};
    end
endmodule

// File: rtl/tagrand_chk.sv
module tagrand_chk #(
    parameter int PTR_W   = 64,
    parameter int TAG_W   = 4,
    parameter int TAG_LSB = 56,
    parameter int ST_W    = 24,
    localparam int NTAGS  = 1 << TAG_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [ST_W-1:0]  st_q,
    input logic [PTR_W-1:0] res_ptr,
    input logic [PTR_W-1:0] ptr_q,
    input logic [NTAGS-1:0] excl_q,
    input logic             en_q,
    input logic [TAG_W-1:0] res_tag_q
);
    localparam logic [PTR_W-1:0] FIELD = PTR_W'((1 << TAG_W) - 1) << TAG_LSB;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> $stable(st_q));

    // R4
    not_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en_q && !(&excl_q)) |-> !excl_q[res_tag_q]);

    // R8
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !en_q) |-> ($stable(st_q) && res_tag_q == '0));

    // R9
    ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((res_ptr ^ ptr_q) & ~FIELD) == '0));

    // R6
    all_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en_q && (&excl_q)) |-> (st_q[TAG_W-1:0] == '0));
endmodule

bind tagrand_top tagrand_chk #(
    .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB), .ST_W(ST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .st_q      (st_q),
    .res_ptr   (res_ptr),
    .ptr_q     (ptr_q),
    .excl_q    (excl_q),
    .en_q      (en_q),
    .res_tag_q (res_tag_q)
);

// File: tb/tb_tagrand_top.sv
module tb_tagrand_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_ptr = '0;
    logic [15:0] req_mask = '0;
    logic [15:0] cfg_mask = '0;
    logic        tag_en = 1'b0;
    logic        st_wr_en = 1'b0;
    logic [23:0] st_wr_data = '0;
    logic        busy, done;
    logic [63:0] res_ptr;
    logic [23:0] st_q;

    always #10 clk = ~clk;

    tagrand_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
        .req_mask(req_mask), .cfg_mask(cfg_mask), .tag_en(tag_en),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .busy(busy),
        .done(done), .res_ptr(res_ptr), .st_q(st_q)
    );

    typedef struct {
        logic [63:0] ptr;
        logic [23:0] st;
        string       rq;
    } exp_t;

    exp_t        sbq[$];
    int          nvec = 0;
    int          nfail = 0;
    int          pushes = 0;
    int          dones = 0;
    logic [23:0] m_st = '0;

    task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [3:0] pick(logic [3:0] start, logic [3:0] off,
                                        logic [15:0] ex);
        logic [3:0] t;
        if (ex == 16'hffff) return 4'd0;
        t = start;
        if (off == 0) begin
            while (ex[t]) t = t + 4'd1;
        end else begin
            for (int k = 0; k < off; k++) begin
                t = t + 4'd1;
                while (ex[t]) t = t + 4'd1;
            end
        end
        return t;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            dones++;
            if (sbq.size() == 0) begin
                check("R10 unexpected done", 64'd1, 64'd0);
            end else begin
                e = sbq.pop_front();
                check({e.rq, " ptr"}, res_ptr, e.ptr);
                check({e.rq, " state"}, {40'd0, st_q}, {40'd0, e.st});
            end
        end
    end

    task automatic wr_state(logic [23:0] d);
        @(posedge clk); #1;
        st_wr_en = 1'b1; st_wr_data = d;
        @(posedge clk); #1;
        st_wr_en = 1'b0;
        m_st = {d[23:8], 4'd0, d[3:0]};
        @(negedge clk);
        check("R11 state write", {40'd0, st_q}, {40'd0, m_st});
    endtask

    task automatic issue(logic [63:0] p, logic [15:0] rm, logic [15:0] cm,
                         logic en, string rq, bit stray);
        logic [15:0] s;
        logic [3:0]  off;
        logic [3:0]  t;
        logic        fb;
        exp_t        e;
        s = m_st[23:8];
        off = '0;
        for (int i = 0; i < 4; i++) begin
            fb = s[5] ^ s[3] ^ s[2] ^ s[0];
            s = {fb, s[15:1]};
            off[i] = fb;
        end
        if (en) begin
            t = pick(m_st[3:0], off, rm | cm);
            m_st = {s, 4'd0, t};
        end else begin
            t = 4'd0;
        end
        e.ptr = p;
        e.ptr[59:56] = t - {3'd0, p[55]};
        e.st = m_st;
        e.rq = rq;
        sbq.push_back(e);
        pushes++;
        @(posedge clk); #1;
        req_valid = 1'b1; req_ptr = p; req_mask = rm; cfg_mask = cm; tag_en = en;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (stray) begin
            // R10 request while busy is ignored; R11 write while busy is ignored
            req_valid = 1'b1; req_ptr = ~p; tag_en = ~en;
            st_wr_en = 1'b1; st_wr_data = 24'h5a5a5a;
            @(posedge clk); #1;
            req_valid = 1'b0; st_wr_en = 1'b0;
        end
        do @(negedge clk); while (busy);
        if (stray) check("R11 write while busy ignored", {40'd0, st_q}, {40'd0, m_st});
    endtask

    initial begin
        #4000000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [63:0] lcg;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset state", {40'd0, st_q}, 64'd0);
        check("R1 reset busy/done", {62'd0, busy, done}, 64'd0);

        // R11 write port, bits 7:4 read as zero
        wr_state(24'hACE1F3);
        // R3 R4 zero mask
        issue(64'h0012_3456_789A_BCDE, 16'h0000, 16'h0000, 1'b1, "R3 R4 no mask", 1'b0);
        // R2 exclusions from config only
        issue(64'h00FF_0000_1111_2222, 16'h0000, 16'h0F0F, 1'b1, "R2 cfg mask", 1'b0);
        // R2 exclusions from request only
        issue(64'h0F00_0000_0000_0040, 16'hF0F0, 16'h0000, 1'b1, "R2 req mask", 1'b0);
        // R5 single allowed tag
        issue(64'h0000_0000_0000_0001, 16'hFFF7, 16'h0000, 1'b1, "R5 one allowed", 1'b0);
        // R6 all excluded
        issue(64'h1234_5678_9ABC_DEF0, 16'hFF00, 16'h00FF, 1'b1, "R6 all excluded", 1'b0);
        // R9 bias with bit 55 set after tag 0
        issue(64'h0080_0000_0000_0000, 16'hFFFF, 16'h0000, 1'b1, "R9 bias wrap", 1'b0);
        // R8 disabled
        issue(64'h0080_0000_DEAD_BEEF, 16'h0001, 16'h0000, 1'b0, "R8 disabled", 1'b0);
        // R10 stray request and write while busy
        issue(64'h0000_1111_2222_3333, 16'h0100, 16'h0000, 1'b1, "R10 stray", 1'b1);
        issue(64'h0080_4444_5555_6666, 16'h0000, 16'h0000, 1'b0, "R10 stray disabled", 1'b1);

        // R4 offset zero path from zero seed
        wr_state(24'h00000E);
        issue(64'h0000_0000_0000_0000, 16'hC000, 16'h0000, 1'b1, "R4 offset zero wrap", 1'b0);

        // R11 write beats same-cycle request
        @(posedge clk); #1;
        req_valid = 1'b1; st_wr_en = 1'b1; st_wr_data = 24'h9C3BF7; tag_en = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0; st_wr_en = 1'b0;
        m_st = 24'h9C3B07;
        repeat (4) @(negedge clk);
        check("R11 request dropped on write", {63'd0, busy}, 64'd0);
        check("R11 write wins", {40'd0, st_q}, {40'd0, m_st});

        // R5 varied patterns
        lcg = 64'h0123_4567_89AB_CDEF;
        for (int n = 0; n < 60; n++) begin
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            issue(lcg, lcg[47:32] & lcg[31:16], lcg[15:0] & lcg[63:48],
                  (n % 9) != 4, "R5 walk", (n % 7) == 3);
        end

        repeat (3) @(negedge clk);
        // R10 one done per accepted request
        check("R10 done count", 64'(dones), 64'(pushes));
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule